// File: doc/BRIEF.md
# Bit-Level Crosspoint Routing Matrix with Staged Configuration

This block connects a set of single-bit array-side sources to the same number of single-bit destinations. Every destination selects at most one source, and any source may feed any number of destinations, so no connection ever blocks another. The data path is purely combinational: a destination output follows its selected source input in the same cycle.

Configuration is written one edit at a time. Each command names a source index, a destination index and an operation, either connect or disconnect. Edits land in a staged copy of the selection table. A single global update strobe copies the whole staged table into the active table at one clock edge, so a large reroute takes effect all at once. A readback port reports the staged selection of any destination. A pending flag shows whether the staged and active tables differ. Reset clears both tables to no-connect.

Command, update and readback pins are plain control and status signals. There is no streaming payload, so there is no valid/ready handshake and no back-pressure: every command is taken in the cycle it is presented.

Top module: `xbar_route_matrix`

## Requirements
- R1: While destination d is actively connected to source s, `dst_data[d]` equals `src_data[s]` in the same cycle, where bit i of each bus is port i. Several destinations may be connected to one source at once.
- R2: A destination with no active connection drives 0 on its bit of `dst_data`.
- R3: While `rst_n` is low, and directly after it rises, every staged and active entry is no-connect, `dst_data` is 0 and `pending` is 0.
- R4: A command changes only the staged table. `dst_data` keeps its mapping until an update.
- R5: When `update` is high at a clock edge, the active table takes the staged contents as they stood before that edge. A command in the same cycle goes only into the staged table.
- R6: A connect command (`cmd_op` = 1) to a destination that already has a staged source replaces that source.
- R7: A disconnect command (`cmd_op` = 0) clears a destination's staged entry only if its staged source equals `cmd_src`. Otherwise the command has no effect.
- R8: A command whose `cmd_src` or `cmd_dst` is NPORT or greater is ignored.
- R9: `rb_hit` and `rb_src` report the staged entry of destination `rb_dst` combinationally. An `rb_dst` of NPORT or greater reads `rb_hit` = 0 and `rb_src` = 0.
- R10: `pending` is 1 exactly when at least one destination's staged entry differs from its active entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 1 = connect, 0 = disconnect |
| cmd_src | input | IDX_W | Source port index |
| cmd_dst | input | IDX_W | Destination port index |
| update | input | 1 | Copy staged table to active table |
| rb_dst | input | IDX_W | Destination to read back |
| rb_hit | output | 1 | Staged entry of rb_dst is connected |
| rb_src | output | IDX_W | Staged source of rb_dst (0 if none) |
| pending | output | 1 | Staged and active tables differ |
| src_data | input | NPORT | Source data, bit i = port i |
| dst_data | output | NPORT | Destination data, bit i = port i |

## Verification
Commands and updates are registered. A command presented before edge k is visible on `rb_hit`/`rb_src` and `pending` right after edge k. An update at edge k changes `dst_data` from edge k on. Readback and the data path have no register, so they follow `rb_dst` and `src_data` within the same cycle. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Readback and pure data checks are sampled one time step after the inputs change, with no clock edge in between.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {
    XB_DISCONNECT = 1'b0,
    XB_CONNECT    = 1'b1
  } xb_op_e;

endpackage

// File: rtl/xbar_cmd_decode.sv
// Range-checks a command and produces a one-hot destination strobe.
module xbar_cmd_decode #(
  parameter int NPORT = 6,
  parameter int IDX_W = $clog2(NPORT + 1)
) (
  input  logic             cmd_en,
  input  logic [IDX_W-1:0] cmd_src,
  input  logic [IDX_W-1:0] cmd_dst,
  output logic [NPORT-1:0] dst_hit
);

  logic src_ok;
  logic dst_ok;

  always_comb begin
    src_ok = int'(cmd_src) < NPORT;
    dst_ok = int'(cmd_dst) < NPORT;
  end

  for (genvar d = 0; d < NPORT; d++) begin : g_hit
    assign dst_hit[d] = cmd_en && src_ok && dst_ok && (int'(cmd_dst) == d);
  end

endmodule

// File: rtl/xbar_cfg_cell.sv
// Staged and active selection for one destination.
module xbar_cfg_cell
  import xbar_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  xb_op_e           op,
  input  logic [IDX_W-1:0] src,
  input  logic             update,
  output logic             stg_vld,
  output logic [IDX_W-1:0] stg_src,
  output logic             act_vld,
  output logic [IDX_W-1:0] act_src,
  output logic             differs
);

  logic             nxt_vld;
  logic [IDX_W-1:0] nxt_src;

  always_comb begin
    nxt_vld = stg_vld;
    nxt_src = stg_src;
    if (hit) begin
      if (op == XB_CONNECT) begin
        nxt_vld = 1'b1;
        nxt_src = src;
      end else if (stg_vld && (stg_src == src)) begin
        nxt_vld = 1'b0;
        nxt_src = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld <= 1'b0;
      stg_src <= '0;
      act_vld <= 1'b0;
      act_src <= '0;
    end else begin
      stg_vld <= nxt_vld;
      stg_src <= nxt_src;
      if (update) begin
        act_vld <= stg_vld;
        act_src <= stg_src;
      end
    end
  end

  always_comb begin
    differs = (stg_vld != act_vld) || (stg_vld && (stg_src != act_src));
  end

endmodule

// File: rtl/xbar_out_mux.sv
// Combinational source selection for one destination.
module xbar_out_mux #(
  parameter int NPORT = 6,
  parameter int IDX_W = 3
) (
  input  logic             sel_vld,
  input  logic [IDX_W-1:0] sel_src,
  input  logic [NPORT-1:0] src_data,
  output logic             dout
);

  always_comb begin
    dout = 1'b0;
    for (int s = 0; s < NPORT; s++) begin
      if (sel_vld && (int'(sel_src) == s)) dout = src_data[s];
    end
  end

endmodule

// File: rtl/xbar_route_matrix.sv
module xbar_route_matrix
  import xbar_pkg::*;
#(
  parameter int NPORT = 6,
  parameter int IDX_W = $clog2(NPORT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  logic             cmd_op,
  input  logic [IDX_W-1:0] cmd_src,
  input  logic [IDX_W-1:0] cmd_dst,
  input  logic             update,
  input  logic [IDX_W-1:0] rb_dst,
  output logic             rb_hit,
  output logic [IDX_W-1:0] rb_src,
  output logic             pending,
  input  logic [NPORT-1:0] src_data,
  output logic [NPORT-1:0] dst_data
);

  logic [NPORT-1:0] dst_hit;
  logic [NPORT-1:0] stg_vld;
  logic [NPORT-1:0] act_vld;
  logic [NPORT-1:0] differs;
  logic [IDX_W-1:0] stg_src [NPORT];
  logic [IDX_W-1:0] act_src [NPORT];
  xb_op_e           op;

  assign op = xb_op_e'(cmd_op);

  xbar_cmd_decode #(.NPORT(NPORT), .IDX_W(IDX_W)) u_dec (
    .cmd_en  (cmd_en),
    .cmd_src (cmd_src),
    .cmd_dst (cmd_dst),
    .dst_hit (dst_hit)
  );

  for (genvar d = 0; d < NPORT; d++) begin : g_dst
    xbar_cfg_cell #(.IDX_W(IDX_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (dst_hit[d]),
      .op      (op),
      .src     (cmd_src),
      .update  (update),
      .stg_vld (stg_vld[d]),
      .stg_src (stg_src[d]),
      .act_vld (act_vld[d]),
      .act_src (act_src[d]),
      .differs (differs[d])
    );

    xbar_out_mux #(.NPORT(NPORT), .IDX_W(IDX_W)) u_mux (
      .sel_vld  (act_vld[d]),
      .sel_src  (act_src[d]),
      .src_data (src_data),
      .dout     (dst_data[d])
    );
  end

  always_comb begin
    rb_hit = 1'b0;
    rb_src = '0;
    for (int d = 0; d < NPORT; d++) begin
      if (int'(rb_dst) == d) begin
        rb_hit = stg_vld[d];
        rb_src = stg_src[d];
      end
    end
  end

  assign pending = |differs;

endmodule

// File: rtl/xbar_route_checker.sv
module xbar_route_checker #(
  parameter int NPORT = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_en,
  input logic             cmd_op,
  input logic [IDX_W-1:0] cmd_src,
  input logic [IDX_W-1:0] cmd_dst,
  input logic             update,
  input logic [IDX_W-1:0] rb_dst,
  input logic             rb_hit,
  input logic [IDX_W-1:0] rb_src,
  input logic             pending,
  input logic [NPORT-1:0] src_data,
  input logic [NPORT-1:0] dst_data
);

  logic bad_cmd;
  assign bad_cmd = (int'(cmd_src) >= NPORT) || (int'(cmd_dst) >= NPORT);

  // R3: leaving reset, nothing is connected and nothing is pending
  a_r3_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dst_data == '0) && !pending);

  // R4: without an update, the data mapping cannot change
  a_r4_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> ($stable(src_data) |-> $stable(dst_data)));

  // R8: an out-of-range command leaves the pending state untouched
  a_r8_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && bad_cmd && !update) |=> $stable(pending));

  // R9: out-of-range readback reads as empty
  a_r9_rb_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rb_dst) >= NPORT) |-> (!rb_hit && (rb_src == '0)));

  // R9: a connected readback names a real port
  a_r9_rb_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rb_hit |-> (int'(rb_src) < NPORT));

  // R10: an update with no concurrent command leaves the tables equal
  a_r10_synced: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !cmd_en) |=> !pending);

endmodule

bind xbar_route_matrix xbar_route_checker #(.NPORT(NPORT), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_en   (cmd_en),
  .cmd_op   (cmd_op),
  .cmd_src  (cmd_src),
  .cmd_dst  (cmd_dst),
  .update   (update),
  .rb_dst   (rb_dst),
  .rb_hit   (rb_hit),
  .rb_src   (rb_src),
  .pending  (pending),
  .src_data (src_data),
  .dst_data (dst_data)
);

// File: tb/tb_xbar_route_matrix.sv
module tb_xbar_route_matrix;

  localparam int NPORT = 6;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_en = 1'b0;
  logic             cmd_op = 1'b0;
  logic [IDX_W-1:0] cmd_src = '0;
  logic [IDX_W-1:0] cmd_dst = '0;
  logic             update = 1'b0;
  logic [IDX_W-1:0] rb_dst = '0;
  logic             rb_hit;
  logic [IDX_W-1:0] rb_src;
  logic             pending;
  logic [NPORT-1:0] src_data = '0;
  logic [NPORT-1:0] dst_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  xbar_route_matrix #(.NPORT(NPORT), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .update(update),
    .rb_dst(rb_dst), .rb_hit(rb_hit), .rb_src(rb_src), .pending(pending),
    .src_data(src_data), .dst_data(dst_data)
  );

  typedef struct packed {
    logic       en;
    logic       op;
    logic [2:0] src;
    logic [2:0] dst;
    logic       upd;
    logic [5:0] din;
    logic [5:0] exp_out;
    logic       exp_pend;
  } vec_t;

  // op: 1 connect, 0 disconnect
  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b1, 3'd0, 3'd1, 1'b0, 6'b111111, 6'b000000, 1'b1}, // R4 staged only
    '{1'b1, 1'b1, 3'd0, 3'd2, 1'b1, 6'b000001, 6'b000010, 1'b1}, // R5 same-cycle cmd
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 6'b000001, 6'b000110, 1'b0}, // R1 one-to-many
    '{1'b1, 1'b1, 3'd3, 3'd1, 1'b0, 6'b001000, 6'b000000, 1'b1}, // R6 replace staged
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 6'b001001, 6'b000110, 1'b0}, // R6 replace active
    '{1'b1, 1'b0, 3'd0, 3'd1, 1'b0, 6'b001001, 6'b000110, 1'b0}, // R7 mismatch ignored
    '{1'b1, 1'b0, 3'd3, 3'd1, 1'b0, 6'b001001, 6'b000110, 1'b1}, // R7 matching disconnect
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 6'b001001, 6'b000100, 1'b0}, // R2 unconnected is 0
    '{1'b1, 1'b1, 3'd7, 3'd4, 1'b0, 6'b111111, 6'b000100, 1'b0}, // R8 bad source
    '{1'b1, 1'b1, 3'd2, 3'd6, 1'b0, 6'b111111, 6'b000100, 1'b0}, // R8 bad destination
    '{1'b1, 1'b1, 3'd5, 3'd5, 1'b1, 6'b100000, 6'b000000, 1'b1}, // R5 update takes old
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 6'b100000, 6'b100000, 1'b0}, // R1 port to itself
    '{1'b1, 1'b1, 3'd5, 3'd0, 1'b0, 6'b100001, 6'b100100, 1'b1}, // R10 pending set
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 6'b100000, 6'b100001, 1'b0}  // R1 fan-out of port 5
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic rb_check(input int d, input bit hit_e, input int src_e, input string tag);
    rb_dst = IDX_W'(d);
    #1;
    chk(rb_hit == hit_e, tag, int'(rb_hit), int'(hit_e));
    chk(int'(rb_src) == src_e, tag, int'(rb_src), src_e);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    src_data = '1;
    #1;
    chk(dst_data == '0, "R3 reset outputs", int'(dst_data), 0);
    chk(!pending, "R3 reset pending", int'(pending), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      cmd_en   = VEC[i].en;
      cmd_op   = VEC[i].op;
      cmd_src  = VEC[i].src;
      cmd_dst  = VEC[i].dst;
      update   = VEC[i].upd;
      src_data = VEC[i].din;
      @(posedge clk);
      @(negedge clk);
      cmd_en = 1'b0;
      update = 1'b0;
      #1;
      chk(dst_data == VEC[i].exp_out, $sformatf("vec %0d dst_data", i),
          int'(dst_data), int'(VEC[i].exp_out));
      chk(pending == VEC[i].exp_pend, $sformatf("R10 vec %0d pending", i),
          int'(pending), int'(VEC[i].exp_pend));
    end

    // Staged table now: 0<-5, 2<-0, 5<-5, others empty
    rb_check(0, 1'b1, 5, "R9 readback dst0");
    rb_check(2, 1'b1, 0, "R9 readback dst2");
    rb_check(1, 1'b0, 0, "R9 readback empty dst1");
    rb_check(7, 1'b0, 0, "R9 readback out of range");

    // R1: data path follows source in the same cycle
    src_data = 6'b000001;
    #1;
    chk(dst_data == 6'b000100, "R1 flow-through", int'(dst_data), 6'b000100);

    // R8: out-of-range command leaves readback untouched
    @(negedge clk);
    cmd_en = 1'b1; cmd_op = 1'b1; cmd_src = 3'd6; cmd_dst = 3'd2;
    @(posedge clk);
    @(negedge clk);
    cmd_en = 1'b0;
    rb_check(2, 1'b1, 0, "R8 readback unchanged");

    // R3: reset in the middle of a configuration
    cmd_en = 1'b1; cmd_op = 1'b1; cmd_src = 3'd1; cmd_dst = 3'd3;
    @(posedge clk);
    @(negedge clk);
    cmd_en = 1'b0;
    rst_n  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    src_data = '1;
    #1;
    chk(dst_data == '0, "R3 mid reset outputs", int'(dst_data), 0);
    chk(!pending, "R3 mid reset pending", int'(pending), 0);
    rb_check(3, 1'b0, 0, "R3 mid reset readback");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule